// File: doc/BRIEF.md
# Clock Generator Fault Recovery Sequencer

This block is the control state machine that brings a faulted on-chip clock generator back into service. An external monitor compares the generated clock against a trusted reference and raises a fault level when the two disagree. When the sequencer is idle and sees that level, it latches the correction method the operator has selected. It then drives the generator's reset, asks an external engine to rewrite the generator's configuration, or does both, in the order the method defines.

After every corrective action, the sequencer waits for the generator to lock. The lock timeout is a parameter, so it can cover a short de-skew lock or a multi-millisecond synthesis lock. The generator's own lock output is never taken as proof of health. Recovery is confirmed only when the monitor's fault level stays low for a whole check window after lock. A configuration rewrite leaves the clock running, so the lock loss it may cause is not counted as a failure.

The outcome is reported as a result code. This lets upsets cleared by a reset alone (data-path upsets) be logged apart from those that needed a configuration rewrite. If every step fails, a failure flag is set and stays set until the block's own reset.

Top module: `clk_recovery_seq`

## Requirements
- R1: Method encoding on `mode_i`: 0 automatic, 1 reset only, 2 rewrite only, 3 rewrite then reset. The method is latched when `fault_i` is seen in idle, and changes to `mode_i` during a sequence have no effect on it.
- R2: Each reset pulse on `gen_rst_o` lasts exactly `RST_CYCLES` consecutive cycles, and `RST_CYCLES` is at least 3.
- R3: After a reset pulse the sequencer waits up to `LOCK_TIMEOUT` cycles for `lock_i`. If no lock arrives in that time, the step counts as not recovered.
- R4: A step succeeds only if `fault_i` stays low for `CHECK_CYCLES` cycles after lock. If `lock_i` is high while the fault persists, the step fails.
- R5: In automatic mode the block first applies one reset. If that fails, it issues one rewrite followed by one more reset, and then judges the outcome.
- R6: `scrub_req_o` stays high until `scrub_done_i` is seen. A low `lock_i` during the rewrite is not a failure. In rewrite-only mode the check window follows the rewrite directly.
- R7: `result_o` is 0 after reset, 1 when the fault was cleared without a rewrite, 2 when a rewrite was part of the successful sequence, and 3 when the fault was not cleared.
- R8: An unrecovered outcome sets `fail_o`, which stays high through later sequences until `rst_ni` is asserted.
- R9: `done_o` is a single-cycle pulse at the end of every sequence, and `result_o` is valid from that cycle onward.
- R10: `fault_i` activity outside idle and the check window, such as a glitch while waiting for lock, neither restarts nor ends the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Operator correction method |
| fault_i | input | 1 | Fault level from the external frequency monitor |
| lock_i | input | 1 | Lock output of the clock generator |
| scrub_done_i | input | 1 | Configuration rewrite finished |
| gen_rst_o | output | 1 | Reset to the clock generator |
| scrub_req_o | output | 1 | Request to the configuration rewrite engine |
| result_o | output | 2 | Outcome code of the last sequence |
| done_o | output | 1 | Sequence finished pulse |
| fail_o | output | 1 | Sticky unrecovered flag |

## Verification
The bench builds the block with a 3-cycle reset pulse, a 20-cycle lock timeout and an 8-cycle check window. With these values, a lock that never arrives reaches its timeout and escalation within a few dozen cycles. A bench model of the generator, the monitor and the rewrite engine can clear the fault at the reset, clear it at the rewrite, or never clear it, so every method meets every outcome. The model also drops lock during a rewrite, injects a fault glitch while the block waits for lock, and changes the method mid-sequence.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    M_AUTO  = 2'd0,
    M_RST   = 2'd1,
    M_SCRUB = 2'd2,
    M_BOTH  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RESET,
    S_WLOCK,
    S_CHECK,
    S_SCRUB,
    S_UNREC,
    S_DONE
  } state_e;

  localparam logic [1:0] RES_NONE  = 2'd0;
  localparam logic [1:0] RES_RST   = 2'd1;
  localparam logic [1:0] RES_SCRUB = 2'd2;
  localparam logic [1:0] RES_FAIL  = 2'd3;
endpackage

// File: rtl/crs_timer.sv
module crs_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3: the window counts down one step per cycle
  a_r3_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
  import crs_pkg::*;
#(
  parameter int RST_CYCLES   = 3,
  parameter int LOCK_TIMEOUT = 1000,
  parameter int CHECK_CYCLES = 64,
  parameter int CW           = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          fault_i,
  input  logic          lock_i,
  input  logic          scrub_done_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          gen_rst_o,
  output logic          scrub_req_o,
  output logic [1:0]    result_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam logic [CW-1:0] RST_V  = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] LOCK_V = CW'(LOCK_TIMEOUT - 1);
  localparam logic [CW-1:0] CHK_V  = CW'(CHECK_CYCLES - 1);

  state_e     state_q, state_d;
  mode_e      mode_q, mode_sel;
  logic       scrubbed_q;
  logic       step_fail;
  logic [1:0] result_q;
  logic       fail_q;

  // idle uses the live method, later states the latched one
  assign mode_sel = (state_q == S_IDLE) ? mode_e'(mode_i) : mode_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    step_fail  = 1'b0;
    unique case (state_q)
      S_IDLE: if (fault_i) begin
        if (mode_sel == M_AUTO || mode_sel == M_RST) begin
          state_d = S_RESET; tmr_load_o = 1'b1; tmr_val_o = RST_V;
        end else begin
          state_d = S_SCRUB;
        end
      end
      S_RESET: if (tmr_zero_i) begin
        state_d = S_WLOCK; tmr_load_o = 1'b1; tmr_val_o = LOCK_V;
      end
      S_WLOCK: begin
        if (lock_i) begin
          state_d = S_CHECK; tmr_load_o = 1'b1; tmr_val_o = CHK_V;
        end else if (tmr_zero_i) begin
          step_fail = 1'b1;
        end
      end
      S_CHECK: begin
        if (fault_i)         step_fail = 1'b1;
        else if (tmr_zero_i) state_d = S_DONE;
      end
      S_SCRUB: if (scrub_done_i) begin
        tmr_load_o = 1'b1;
        if (mode_sel == M_SCRUB) begin
          state_d = S_CHECK; tmr_val_o = CHK_V;
        end else begin
          state_d = S_RESET; tmr_val_o = RST_V;
        end
      end
      S_UNREC: state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (step_fail) begin
      state_d = (mode_sel == M_AUTO && !scrubbed_q) ? S_SCRUB : S_UNREC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mode_q     <= M_AUTO;
      scrubbed_q <= 1'b0;
      result_q   <= RES_NONE;
      fail_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        mode_q     <= mode_sel;
        scrubbed_q <= 1'b0;
      end else if (state_q == S_SCRUB) begin
        scrubbed_q <= 1'b1;
      end
      if (state_d == S_DONE && state_q != S_DONE) begin
        if (state_q == S_UNREC) result_q <= RES_FAIL;
        else                    result_q <= scrubbed_q ? RES_SCRUB : RES_RST;
      end
      if (state_q == S_UNREC) fail_q <= 1'b1;
    end
  end

  assign gen_rst_o   = (state_q == S_RESET);
  assign scrub_req_o = (state_q == S_SCRUB);
  assign done_o      = (state_q == S_DONE);
  assign result_o    = result_q;
  assign fail_o      = fail_q;

  // pulse-width tracker for the reset assertion
  logic [CW-1:0] rwid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rwid_q <= '0;
    else if (gen_rst_o) rwid_q <= rwid_q + 1'b1;
    else                rwid_q <= '0;
  end

  a_r2_rst_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gen_rst_o) |-> (rwid_q == CW'(RST_CYCLES)));
  a_r2_rst_min: assert final (RST_CYCLES >= 3);
  a_r6_scrub_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scrub_req_o && !scrub_done_i) |=> scrub_req_o);
  a_r8_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_unrec_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o == RES_FAIL) |-> fail_o);
  a_r7_done_coded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o != RES_NONE));
endmodule

// File: rtl/clk_recovery_seq.sv
module clk_recovery_seq #(
  parameter int RST_CYCLES   = 3,
  parameter int LOCK_TIMEOUT = 1_000_000,
  parameter int CHECK_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       fault_i,
  input  logic       lock_i,
  input  logic       scrub_done_i,
  output logic       gen_rst_o,
  output logic       scrub_req_o,
  output logic [1:0] result_o,
  output logic       done_o,
  output logic       fail_o
);
  localparam int MAX_A = (LOCK_TIMEOUT > CHECK_CYCLES) ? LOCK_TIMEOUT : CHECK_CYCLES;
  localparam int MAX_V = (MAX_A > RST_CYCLES) ? MAX_A : RST_CYCLES;
  localparam int CW    = $clog2(MAX_V + 1);

  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  crs_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  crs_fsm #(
    .RST_CYCLES   (RST_CYCLES),
    .LOCK_TIMEOUT (LOCK_TIMEOUT),
    .CHECK_CYCLES (CHECK_CYCLES),
    .CW           (CW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .fault_i      (fault_i),
    .lock_i       (lock_i),
    .scrub_done_i (scrub_done_i),
    .tmr_zero_i   (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .gen_rst_o    (gen_rst_o),
    .scrub_req_o  (scrub_req_o),
    .result_o     (result_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
  );
endmodule

// File: tb/sim_clk_recovery_seq.sv
module sim_clk_recovery_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC = 3;
  localparam int LTO  = 20;
  localparam int CHK  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       fault, lock, scrub_done = 1'b0;
  logic       gen_rst, scrub_req, done, fail;
  logic [1:0] result;

  int  tests = 0, fails = 0, cyc = 0;
  logic [1:0] exp_q[$];

  // environment model state
  logic fault_req = 1'b0, cleared = 1'b0, glitch = 1'b0, glitch_en = 1'b0;
  logic lock_m = 1'b1, rst_prev = 1'b0, sreq_prev = 1'b0;
  int   fix = 0, lock_delay = 5, lcnt = 0, scnt = 0, gcnt = 0, rwid = 0;
  int   n_rst = 0, n_scr = 0;

  assign fault = (fault_req && !cleared) || glitch;
  assign lock  = lock_m && !scrub_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_recovery_seq #(.RST_CYCLES(RSTC), .LOCK_TIMEOUT(LTO), .CHECK_CYCLES(CHK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fault_i(fault), .lock_i(lock),
    .scrub_done_i(scrub_done), .gen_rst_o(gen_rst), .scrub_req_o(scrub_req),
    .result_o(result), .done_o(done), .fail_o(fail));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // generator, monitor and rewrite-engine model
  always @(negedge clk) begin
    if (gen_rst && !rst_prev) n_rst++;
    if (scrub_req && !sreq_prev) n_scr++;
    if (gen_rst) rwid++;
    else if (rst_prev) begin
      chk(rwid == RSTC, "R2 reset width", rwid, RSTC);
      rwid = 0;
    end
    if (gen_rst) begin lock_m = 1'b0; lcnt = 0; end
    else if (!lock_m) begin lcnt++; if (lcnt >= lock_delay) lock_m = 1'b1; end
    if (scrub_req) begin
      scnt++;
      scrub_done = (scnt == 4);
      if (scnt == 4 && fix == 1) cleared = 1'b1;
    end else begin
      scnt = 0; scrub_done = 1'b0;
    end
    if (!fault_req) cleared = 1'b0;
    else if (!gen_rst && rst_prev && fix == 0) cleared = 1'b1;
    if (!gen_rst && rst_prev) gcnt = 0; else gcnt++;
    glitch = glitch_en && (gcnt == 2);
    rst_prev  = gen_rst;
    sreq_prev = scrub_req;
  end

  // scoreboard monitor
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_prev) chk(1'b0, "R9 done held two cycles", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(result == e, "R7 result code", result, e);
        end
      end
    end
    done_prev = done;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_case(input logic [1:0] m, input int f, input int ld, input bit chg,
                          input logic [1:0] exp, input int e_rst, input int e_scr,
                          input string tag);
    int r0, s0;
    mode = m; fix = f; lock_delay = ld;
    r0 = n_rst; s0 = n_scr;
    exp_q.push_back(exp);
    fault_req = 1'b1;
    @(negedge clk);
    if (chg) begin repeat (2) @(negedge clk); mode = 2'd0; end
    while (!done) @(negedge clk);
    fault_req = 1'b0;
    @(negedge clk);
    chk(n_rst - r0 == e_rst, {tag, " reset pulses"}, n_rst - r0, e_rst);
    chk(n_scr - s0 == e_scr, {tag, " rewrite requests"}, n_scr - s0, e_scr);
    chk(exp_q.size() == 0, {tag, " R9 done seen"}, exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // reset state
    chk(gen_rst == 1'b0, "R2 reset idle", gen_rst, 0);
    chk(scrub_req == 1'b0, "R6 rewrite idle", scrub_req, 0);
    chk(done == 1'b0, "R9 done idle", done, 0);
    chk(result == 2'd0, "R7 reset result", result, 0);
    chk(fail == 1'b0, "R8 reset flag", fail, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R10 auto, cleared by reset, glitch while waiting for lock
    glitch_en = 1'b1;
    run_case(2'd0, 0, 5, 1'b0, 2'd1, 1, 0, "R5 R10 auto reset-fix");
    glitch_en = 1'b0;
    // R5 R4 auto, reset fails with lock high, escalates
    run_case(2'd0, 1, 5, 1'b0, 2'd2, 2, 1, "R5 R4 auto rewrite-fix");
    // R6 rewrite only, lock low during rewrite
    run_case(2'd2, 1, 5, 1'b0, 2'd2, 0, 1, "R6 rewrite-only");
    // R1 rewrite then reset
    run_case(2'd3, 1, 5, 1'b0, 2'd2, 1, 1, "R1 rewrite-then-reset");
    chk(fail == 1'b0, "R8 no flag after recoveries", fail, 0);
    // R7 R8 auto never cleared
    run_case(2'd0, 2, 5, 1'b0, 2'd3, 2, 1, "R7 auto unrecovered");
    chk(fail == 1'b1, "R8 flag set", fail, 1);
    // R1 reset only, method changed mid-sequence, no escalation
    run_case(2'd1, 1, 5, 1'b1, 2'd3, 1, 0, "R1 method latched");
    chk(fail == 1'b1, "R8 flag sticky", fail, 1);
    apply_reset();
    chk(fail == 1'b0, "R8 flag cleared by reset", fail, 0);
    chk(result == 2'd0, "R7 result cleared", result, 0);
    // R3 lock never arrives
    run_case(2'd0, 0, 1000, 1'b0, 2'd3, 2, 1, "R3 lock timeout");
    chk(fail == 1'b1, "R3 timeout flags failure", fail, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule